// File: doc/BRIEF.md
# Byte-Stream Register Access Parser

This block sits between a byte-wide serial receiver/transmitter pair and a register file of 128 entries. The registers do not all have the same width. Every command starts with a command byte. Its upper seven bits give the starting register address and its lowest bit gives the direction. A second byte follows with the number of data bytes to move. For a write, the parser collects that many incoming bytes and packs them into registers. For a read, it streams that many bytes out to the transmitter.

A transfer that runs past the last byte of the current register moves on to the next address. Within each register the most significant byte comes first. A multi-byte register is written only when all of its bytes have arrived, so a register is never left half updated.

Top module: `reg_cmd_parser`

## Requirements
- R1: After reset, tx_valid_o and reg_we_o are low and the parser waits for a command byte.
- R2: In a command byte, bits 7:1 are the register address and bit 0 is the direction: 1 means read, 0 means write.
- R3: The byte after the command byte is the count of data bytes that the command moves.
- R4: The register at address a holds (a mod 4)+1 bytes: address 0 holds 1 byte, 1 holds 2, 2 holds 3 and 3 holds 4, and the pattern repeats.
- R5: A read returns the bytes of each register most significant byte first, taken from the low (size×8) bits of reg_rdata_i.
- R6: A read whose count exceeds the bytes left in the current register continues with the next address.
- R7: A write packs the incoming bytes most significant first. One cycle after the register's last byte is accepted, it raises reg_we_o for one cycle with the value zero-extended on reg_wdata_o.
- R8: A write whose count exceeds the register size continues into the following registers, with one commit per completed register.
- R9: If a write command ends before a register's last byte, that register is not written.
- R10: A count of zero ends the command with no data moved, and the next byte is taken as a new command byte.
- R11: The address after 127 is 0.
- R12: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe, one cycle per byte |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Read byte offered to the transmitter |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |
| tx_data_o | output | 8 | Read byte |
| reg_raddr_o | output | 7 | Register read address |
| reg_rdata_i | input | 32 | Register read data, combinational from reg_raddr_o |
| reg_we_o | output | 1 | Register write strobe |
| reg_waddr_o | output | 7 | Register write address |
| reg_wdata_o | output | 32 | Register write data, zero-extended |

## Verification
The assertion on the read handshake assumes that reg_rdata_i is a pure function of reg_raddr_o and does not change while a read response is stalled. The bench models the register file combinationally, and it writes that model only on reg_we_o, which never fires during a read. The bench also presents received bytes only as single-cycle strobes on whole commands, so the parser's state assertions see only well-formed sequences.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam int NBYTES = DATA_W / 8;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam int SZ_W   = IDX_W + 1;
  localparam int NREGS  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_LEN = 2'd1,
    ST_WR  = 2'd2,
    ST_RD  = 2'd3
  } st_e;

  // Fixed byte width of each register: 1..NBYTES, cycling with address
  function automatic logic [SZ_W-1:0] reg_size(input int a);
    return SZ_W'((a % NBYTES) + 1);
  endfunction
endpackage

// File: rtl/rcp_size_tab.sv
module rcp_size_tab
  import rcp_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SZ_W-1:0]   size_o
);
  logic [SZ_W-1:0] tab [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_ent
    assign tab[g] = reg_size(g);
  end

  assign size_o = tab[addr_i];

  always_comb begin
    assert (size_o != '0 && size_o <= SZ_W'(NBYTES)) else $error("AST_SIZE_RANGE"); // R4
  end
endmodule

// File: rtl/rcp_rd_path.sv
module rcp_rd_path
  import rcp_pkg::*;
(
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [7:0]        byte_o
);
  logic [7:0]       lanes [NBYTES];
  logic [IDX_W-1:0] sel;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = rdata_i[g*8 +: 8];
  end

  // big-endian within register: first byte is the top lane of its size
  assign sel    = IDX_W'(size_i - SZ_W'(1)) - idx_i;
  assign byte_o = lanes[sel];
endmodule

// File: rtl/rcp_wr_asm.sv
module rcp_wr_asm
  import rcp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int ACC_W = DATA_W - 8;

  logic [ACC_W-1:0]  acc_q;
  logic [DATA_W-1:0] packed_v;

  assign packed_v = first_i ? {{ACC_W{1'b0}}, byte_i} : {acc_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= take_i && last_i;
      if (take_i) acc_q <= packed_v[ACC_W-1:0];
      if (take_i && last_i) begin
        waddr_o <= addr_i;
        wdata_o <= packed_v;
      end
    end
  end

  AST_WE_NEEDS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $past(take_i && last_i)); // R9
  AST_FIRST_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && first_i && last_i) |=> (wdata_o[DATA_W-1:8] == '0)); // R7
endmodule

// File: rtl/reg_cmd_parser.sv
module reg_cmd_parser
  import rcp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic [ADDR_W-1:0] reg_raddr_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_we_o,
  output logic [ADDR_W-1:0] reg_waddr_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  st_e              st_q;
  logic [ADDR_W-1:0] addr_q;
  logic             rd_q;
  logic [7:0]       cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [SZ_W-1:0]  cur_size;
  logic             last_b;
  logic             adv;
  logic             take_w;

  rcp_size_tab u_size (
    .addr_i (addr_q),
    .size_o (cur_size)
  );

  assign last_b = (idx_q == IDX_W'(cur_size - SZ_W'(1)));
  assign take_w = (st_q == ST_WR) && rx_valid_i;
  assign adv    = ((st_q == ST_RD) && tx_ready_i) || take_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CMD;
      addr_q <= '0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else begin
      unique case (st_q)
        ST_CMD: if (rx_valid_i) begin
          addr_q <= rx_data_i[7:1];
          rd_q   <= rx_data_i[0];
          st_q   <= ST_LEN;
        end
        ST_LEN: if (rx_valid_i) begin
          cnt_q <= rx_data_i;
          idx_q <= '0;
          if (rx_data_i == 8'd0) st_q <= ST_CMD;
          else                   st_q <= rd_q ? ST_RD : ST_WR;
        end
        default: if (adv) begin
          cnt_q <= cnt_q - 8'd1;
          if (last_b) begin
            idx_q  <= '0;
            addr_q <= addr_q + ADDR_W'(1);  // wraps naturally
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
          if (cnt_q == 8'd1) st_q <= ST_CMD;
        end
      endcase
    end
  end

  assign tx_valid_o  = (st_q == ST_RD);
  assign reg_raddr_o = addr_q;

  rcp_rd_path u_rd (
    .rdata_i (reg_rdata_i),
    .size_i  (cur_size),
    .idx_i   (idx_q),
    .byte_o  (tx_data_o)
  );

  rcp_wr_asm u_wr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take_w),
    .first_i (idx_q == '0),
    .last_i  (last_b),
    .byte_i  (rx_data_i),
    .addr_i  (addr_q),
    .we_o    (reg_we_o),
    .waddr_o (reg_waddr_o),
    .wdata_o (reg_wdata_o)
  );

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R12
  AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEN && rx_valid_i && rx_data_i == 8'd0) |=> (st_q == ST_CMD)); // R10
  AST_ADDR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_RD, ST_WR} && adv && last_b && addr_q == '1) |=> (addr_q == '0)); // R11
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q inside {ST_RD, ST_WR}) |-> (SZ_W'(idx_q) < cur_size)); // R4
  AST_DIR_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CMD && rx_valid_i) |=> (rd_q == $past(rx_data_i[0]))); // R2
  AST_NO_WE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !reg_we_o); // R7
endmodule

// File: tb/sim_reg_cmd_parser.sv
module sim_reg_cmd_parser;
  import rcp_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_ready = 1'b1;
  logic tx_valid;
  logic [7:0] tx_data;
  logic [6:0] raddr, waddr;
  logic [31:0] rdata, wdata;
  logic we;

  int n_chk = 0, n_fail = 0, we_cnt = 0, cyc = 0;
  logic [31:0] mem [128];
  logic [31:0] exp_mem [128];

  always #2.5 clk = ~clk;

  reg_cmd_parser u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .reg_raddr_o(raddr), .reg_rdata_i(rdata), .reg_we_o(we),
    .reg_waddr_o(waddr), .reg_wdata_o(wdata)
  );

  assign rdata = mem[raddr];

  always @(posedge clk) if (we) begin
    mem[waddr] <= wdata;
    we_cnt <= we_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int sz(input int a);
    return (a % 4) + 1;
  endfunction

  function automatic logic [31:0] msk(input int a);
    return (sz(a) == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * sz(a))) - 32'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  // read len bytes from a, compare with expected model; optional stall on byte 1
  task automatic rd_cmd(input int a, input int len, input bit stall, input string req);
    int ca = a, ci = 0;
    send(8'(a << 1) | 8'h01);
    send(8'(len));
    for (int i = 0; i < len; i++) begin
      logic [7:0] eb;
      int w = 0;
      @(negedge clk);
      while (!tx_valid && w < 50) begin @(negedge clk); w++; end
      eb = 8'(exp_mem[ca] >> (8 * (sz(ca) - 1 - ci)));
      chk(tx_valid && tx_data == eb, req, {24'd0, tx_data}, {24'd0, eb});
      if (stall && i == 1) begin
        logic [7:0] held = tx_data;
        tx_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(tx_valid && tx_data == held, "R12", {24'd0, tx_data}, {24'd0, held});
        end
        tx_ready = 1'b1;
      end
      if (ci == sz(ca) - 1) begin ci = 0; ca = (ca + 1) % 128; end
      else ci++;
    end
    @(negedge clk);
    chk(!tx_valid, req, {31'd0, tx_valid}, 32'd0);
  endtask

  // write bytes from data vector (MSB-first stream) and update expected model
  task automatic wr_cmd(input int a, input int len, input logic [7:0] d [16]);
    int ca = a, ci = 0;
    logic [31:0] acc = '0;
    send(8'(a << 1));
    send(8'(len));
    for (int i = 0; i < len; i++) begin
      send(d[i]);
      acc = (ci == 0) ? {24'd0, d[i]} : {acc[23:0], d[i]};
      if (ci == sz(ca) - 1) begin
        exp_mem[ca] = acc & msk(ca);
        ci = 0; ca = (ca + 1) % 128;
      end else ci++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!tx_valid, "R1", {31'd0, tx_valid}, 32'd0);
    chk(!we, "R1", {31'd0, we}, 32'd0);
  endtask

  task automatic t_read_single();
    rd_cmd(3, 4, 1'b0, "R5");   // size 4
    rd_cmd(2, 3, 1'b0, "R4");   // size 3
    rd_cmd(0, 1, 1'b0, "R2");   // size 1
  endtask

  task automatic t_read_span();
    rd_cmd(1, 2 + 3 + 4 + 1, 1'b0, "R6");
    rd_cmd(6, 5, 1'b0, "R3");   // ends mid-register
  endtask

  task automatic t_write_span();
    logic [7:0] d [16];
    int c0;
    for (int i = 0; i < 16; i++) d[i] = 8'(8'h31 + 8'(i * 7));
    c0 = we_cnt;
    wr_cmd(5, 9, d);            // sizes 2,3,4
    chk(we_cnt - c0 == 3, "R8", 32'(we_cnt - c0), 32'd3);
    rd_cmd(5, 9, 1'b0, "R7");
  endtask

  task automatic t_partial();
    logic [7:0] d [16];
    int c0;
    for (int i = 0; i < 16; i++) d[i] = 8'hE0 + 8'(i);
    c0 = we_cnt;
    wr_cmd(11, 3, d);           // size 4, only 3 bytes
    chk(we_cnt == c0, "R9", 32'(we_cnt), 32'(c0));
    chk(mem[11] == exp_mem[11], "R9", mem[11], exp_mem[11]);
    rd_cmd(11, 4, 1'b0, "R9");
  endtask

  task automatic t_zero_len();
    int c0 = we_cnt;
    send(8'(20 << 1) | 8'h01);
    send(8'd0);
    @(negedge clk);
    chk(!tx_valid, "R10", {31'd0, tx_valid}, 32'd0);
    send(8'(21 << 1));
    send(8'd0);
    repeat (2) @(negedge clk);
    chk(we_cnt == c0, "R10", 32'(we_cnt), 32'(c0));
    rd_cmd(21, 2, 1'b0, "R10");
  endtask

  task automatic t_wrap();
    logic [7:0] d [16];
    for (int i = 0; i < 16; i++) d[i] = 8'h90 + 8'(i * 3);
    rd_cmd(127, 6, 1'b0, "R11");
    wr_cmd(127, 5, d);          // 4 bytes to 127, 1 to 0
    rd_cmd(127, 5, 1'b0, "R11");
  endtask

  task automatic t_stall();
    rd_cmd(7, 4, 1'b1, "R12");
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i] = (32'hA1B2_C3D4 ^ (32'(i) * 32'h0101_0101)) & msk(i);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read_single();
    t_read_span();
    t_write_span();
    t_partial();
    t_zero_len();
    t_wrap();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule